// File: doc/BRIEF.md
# Write-back read-allocate data cache

This block is a small direct-mapped data cache. It sits between a processor-side request port and a slower memory port that moves one whole line per transaction. Memory is split into blocks the size of one line, and block n may only be held in line n modulo the line count. Reads allocate lines. Writes never allocate a line. A write that hits changes only the cached copy and leaves memory stale until that line is written back.

Two maintenance commands work on a memory block number instead of an address. A flush copies a resident, modified block back to memory and keeps it cached. An invalidate drops a resident block without copying it back. Software uses a flush before another agent reads memory, and an invalidate after another agent has written memory, so that cache and memory stay coherent.

All requests pass one at a time through a single controller with four states: idle, write-back, fill and respond. The line count, the line size and the address width are parameters. The defaults give two lines of four bytes over a 16-byte address space.

Top module: `wbc_cache`

## Requirements
- R1: Block number b = addr >> log2(LINE_BYTES) lives only in line b mod LINES. Blocks that map to different lines stay resident together. A miss whose victim line holds a clean block does a single memory read and no memory write.
- R2: A write to a block that is not resident does exactly one memory write of block b with mem_be one-hot at bit (addr mod LINE_BYTES), where mem_be bit i enables byte i at mem_wdata[8i+7:8i]. The write allocates no line, so a later read of that block misses.
- R3: A read miss issues one memory read of the whole block (mem_we low, mem_be zero). It installs the line, and only then responds with byte (addr mod LINE_BYTES) of the fetched line (memory byte i at mem_rdata[8i+7:8i]).
- R4: A write hit updates only the cached byte and marks the line modified. It does no memory transaction, so memory keeps its old value.
- R5: A read hit returns the cached byte with no memory transaction, even when memory holds a different value.
- R6: A read miss whose victim line is valid and modified first writes the whole old line (all mem_be bits set) to its own block. It then reads the new block.
- R7: A flush of a resident, modified block writes the whole line to that block. The block stays resident and becomes unmodified, so a second flush or a read of it causes no memory traffic.
- R8: An invalidate of a resident block discards it with no memory traffic, and the next read of that block is served from memory.
- R9: A flush of a block that is not resident, or that is resident but unmodified, causes no memory traffic. This includes a block that was just invalidated.
- R10: req_op encodes 0 read, 1 write, 2 flush and 3 invalidate. Flush and invalidate take their block from req_blk. req_ready is high only when the controller is idle, and it drops in the cycle after a request is accepted. Each accepted request gets exactly one single-cycle rsp_valid pulse. mem_req, mem_blk, mem_we and mem_be stay stable until mem_ack.
- R11: Synchronous reset marks every line invalid and unmodified, raises req_ready, and clears mem_req and rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 read, 1 write, 2 flush, 3 invalidate |
| req_addr | input | ADDR_W | Byte address for read and write |
| req_blk | input | ADDR_W-log2(LINE_BYTES) | Block number for flush and invalidate |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with rsp_valid after a read |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for a memory write, 0 for a line read |
| mem_blk | output | ADDR_W-log2(LINE_BYTES) | Memory block number |
| mem_be | output | LINE_BYTES | Byte enables for a memory write |
| mem_wdata | output | 8*LINE_BYTES | Line data for a memory write |
| mem_rdata | input | 8*LINE_BYTES | Line data returned on a read |
| mem_ack | input | 1 | Memory transaction completes this cycle |

## Verification
The assertions check the handshake rules on every cycle:
- the idle-only ready signal,
- the single-cycle completion pulse,
- memory requests held stable until acknowledged,
- single-byte strobes on non-allocating writes,
- empty strobes on line reads.

Whether data is stale or coherent can only be shown by the bench's scenarios, because it depends on history. These cases include a write hit that leaves memory old, an eviction that writes back, a flush that keeps the line, and an invalidate that throws dirty data away. The bench checks them against a reference model of the cache and memory contents. Those scenarios run a directed walk through every case, then a long pseudo-random sequence over all four blocks, and finish with a full flush that compares memory byte for byte.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND
  } state_e;
endpackage

// File: rtl/wbc_tag_store.sv
// Per-line valid, modified and tag state. Asynchronous lookup, one write port.
module wbc_tag_store #(
  parameter int LINES = 2,
  parameter int TAG_W = 1,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // Tags carry no reset; valid_q gates them.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wbc_line_ram.sv
// Line data storage with per-byte write enables.
module wbc_line_ram #(
  parameter int LINES      = 2,
  parameter int LINE_BYTES = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [LINE_W-1:0]     rd_line,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [LINE_BYTES-1:0] wr_be,
  input  logic [LINE_W-1:0]     wr_line
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (wr_be[b]) mem_q[wr_idx][8*b +: 8] <= wr_line[8*b +: 8];
    end
  end

  assign rd_line = mem_q[rd_idx];
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LINES      = 2,
  parameter int LINE_BYTES = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_valid,
  output logic [7:0]            rsp_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [BLK_W-1:0]      mem_blk,
  output logic [LINE_BYTES-1:0] mem_be,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic [LINE_W-1:0]     mem_rdata,
  input  logic                  mem_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = BLK_W - IDX_W;

  state_e            st;
  op_e               op_q;
  logic [BLK_W-1:0]  blk_q;
  logic [OFF_W-1:0]  off_q;
  logic              fill_after;

  // Lookup: in idle the incoming request selects the line,
  // otherwise the latched block does.
  op_e               in_op;
  logic [OFF_W-1:0]  in_off;
  logic [BLK_W-1:0]  in_blk;
  logic [BLK_W-1:0]  cur_blk;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              t_valid, t_dirty;
  logic [TAG_W-1:0]  t_tag;
  logic [LINE_W-1:0] line_rd;
  logic              hit, accept;

  assign in_op   = op_e'(req_op);
  assign in_off  = req_addr[OFF_W-1:0];
  assign in_blk  = (in_op == OP_FLUSH || in_op == OP_INVAL) ? req_blk
                                                             : req_addr[ADDR_W-1:OFF_W];
  assign cur_blk = (st == ST_IDLE) ? in_blk : blk_q;
  assign cur_idx = cur_blk[IDX_W-1:0];
  assign cur_tag = cur_blk[BLK_W-1:IDX_W];
  assign hit     = t_valid && (t_tag == cur_tag);
  assign accept  = req_valid && req_ready;

  // State and data updates
  logic                  tu_en, tu_valid, tu_dirty;
  logic [TAG_W-1:0]      tu_tag;
  logic [LINE_BYTES-1:0] dw_be;
  logic [LINE_W-1:0]     dw_line;

  always_comb begin
    tu_en    = 1'b0;
    tu_valid = t_valid;
    tu_dirty = t_dirty;
    tu_tag   = t_tag;
    dw_be    = '0;
    dw_line  = {LINE_BYTES{req_wdata}};
    unique case (st)
      ST_IDLE: begin
        if (accept && hit) begin
          if (in_op == OP_WRITE) begin
            tu_en    = 1'b1;
            tu_dirty = 1'b1;
            dw_be    = LINE_BYTES'(1) << in_off;
          end else if (in_op == OP_INVAL) begin
            tu_en    = 1'b1;
            tu_valid = 1'b0;
            tu_dirty = 1'b0;
          end
        end
      end
      ST_WRITEBACK: begin
        if (mem_ack && op_q == OP_FLUSH) begin
          tu_en    = 1'b1;
          tu_dirty = 1'b0;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          tu_en    = 1'b1;
          tu_valid = 1'b1;
          tu_dirty = 1'b0;
          tu_tag   = cur_tag;
          dw_be    = '1;
          dw_line  = mem_rdata;
        end
      end
      default: ;
    endcase
  end

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (cur_idx),
    .rd_valid (t_valid),
    .rd_dirty (t_dirty),
    .rd_tag   (t_tag),
    .wr_en    (tu_en),
    .wr_idx   (cur_idx),
    .wr_valid (tu_valid),
    .wr_dirty (tu_dirty),
    .wr_tag   (tu_tag)
  );

  wbc_line_ram #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_lines (
    .clk     (clk),
    .rd_idx  (cur_idx),
    .rd_line (line_rd),
    .wr_idx  (cur_idx),
    .wr_be   (dw_be),
    .wr_line (dw_line)
  );

  // Controller
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_READ;
      blk_q      <= '0;
      off_q      <= '0;
      fill_after <= 1'b0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_blk    <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            op_q      <= in_op;
            blk_q     <= in_blk;
            off_q     <= in_off;
            req_ready <= 1'b0;
            unique case (in_op)
              OP_READ: begin
                if (hit) begin
                  rsp_rdata <= line_rd[8*in_off +: 8];
                  rsp_valid <= 1'b1;
                  st        <= ST_RESPOND;
                end else if (t_valid && t_dirty) begin
                  // Victim holds modified data: copy it back first.
                  mem_req    <= 1'b1;
                  mem_we     <= 1'b1;
                  mem_blk    <= {t_tag, cur_idx};
                  mem_be     <= '1;
                  mem_wdata  <= line_rd;
                  fill_after <= 1'b1;
                  st         <= ST_WRITEBACK;
                end else begin
                  mem_req <= 1'b1;
                  mem_we  <= 1'b0;
                  mem_blk <= in_blk;
                  mem_be  <= '0;
                  st      <= ST_FILL;
                end
              end
              OP_WRITE: begin
                if (hit) begin
                  rsp_valid <= 1'b1;
                  st        <= ST_RESPOND;
                end else begin
                  // No allocation on a write miss: one byte goes straight out.
                  mem_req    <= 1'b1;
                  mem_we     <= 1'b1;
                  mem_blk    <= in_blk;
                  mem_be     <= LINE_BYTES'(1) << in_off;
                  mem_wdata  <= {LINE_BYTES{req_wdata}};
                  fill_after <= 1'b0;
                  st         <= ST_WRITEBACK;
                end
              end
              OP_FLUSH: begin
                if (hit && t_dirty) begin
                  mem_req    <= 1'b1;
                  mem_we     <= 1'b1;
                  mem_blk    <= in_blk;
                  mem_be     <= '1;
                  mem_wdata  <= line_rd;
                  fill_after <= 1'b0;
                  st         <= ST_WRITEBACK;
                end else begin
                  rsp_valid <= 1'b1;
                  st        <= ST_RESPOND;
                end
              end
              default: begin
                rsp_valid <= 1'b1;
                st        <= ST_RESPOND;
              end
            endcase
          end
        end
        ST_WRITEBACK: begin
          if (mem_ack) begin
            if (fill_after) begin
              mem_we  <= 1'b0;
              mem_blk <= blk_q;
              mem_be  <= '0;
              st      <= ST_FILL;
            end else begin
              mem_req   <= 1'b0;
              mem_we    <= 1'b0;
              mem_be    <= '0;
              rsp_valid <= 1'b1;
              st        <= ST_RESPOND;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            rsp_rdata <= mem_rdata[8*off_q +: 8];
            rsp_valid <= 1'b1;
            st        <= ST_RESPOND;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          req_ready <= 1'b1;
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int BLK_W      = 2,
  parameter int LINE_BYTES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic [BLK_W-1:0]      mem_blk,
  input logic [LINE_BYTES-1:0] mem_be,
  input logic                  mem_ack
);
  assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req && !rsp_valid);

  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_blk) && $stable(mem_we) && $stable(mem_be));

  assert_partial_write_one_byte_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !(&mem_be) |-> $countones(mem_be) == 1);

  assert_line_read_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> mem_be == '0);

  assert_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> req_ready && !mem_req && !rsp_valid);
endmodule

bind wbc_cache wbc_checker #(.BLK_W(BLK_W), .LINE_BYTES(LINE_BYTES)) i_wbc_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_blk   (mem_blk),
  .mem_be    (mem_be),
  .mem_ack   (mem_ack)
);

// File: tb/test_wbc_cache.sv
`timescale 1ns/1ps
module test_wbc_cache;
  localparam int ADDR_W = 4;
  localparam int LINES  = 2;
  localparam int LB     = 4;
  localparam int NBYTES = 1 << ADDR_W;
  localparam int NBLK   = NBYTES / LB;
  localparam int MEM_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_blk = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_req, mem_we;
  logic [1:0]  mem_blk;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  wbc_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LB)) i_wbc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_blk(req_blk), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_blk(mem_blk), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_rd  = 0;
  int n_wr  = 0;
  int lat   = 0;

  logic [7:0] mem_arr [NBYTES];  // memory behind the port
  logic [7:0] ref_mem [NBYTES];  // expected memory contents
  logic       mv [LINES];
  logic       md [LINES];
  int         mt [LINES];
  logic [7:0] mdat [LINES][LB];

  // Memory model: acknowledges after MEM_LAT idle cycles, on a falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat == MEM_LAT) begin
          lat = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            for (int i = 0; i < LB; i++)
              if (mem_be[i]) mem_arr[int'(mem_blk)*LB + i] = mem_wdata[8*i +: 8];
            n_wr++;
          end else begin
            for (int i = 0; i < LB; i++)
              mem_rdata[8*i +: 8] = mem_arr[int'(mem_blk)*LB + i];
            n_rd++;
          end
        end else begin
          lat++;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_back(input int idx);
    for (int i = 0; i < LB; i++) ref_mem[(mt[idx]*LINES + idx)*LB + i] = mdat[idx][i];
  endtask

  // One request: reference model update, then drive and compare at the ports.
  task automatic run(input int op, input int a, input int b, input logic [7:0] wd);
    int blk, off, idx, tg, er, ew, r0, w0, t;
    logic [7:0] erd, got;
    logic hit;
    string req;
    blk = (op >= 2) ? b : (a / LB);
    off = a % LB;
    idx = blk % LINES;
    tg  = blk / LINES;
    hit = mv[idx] && (mt[idx] == tg);
    er = 0; ew = 0; erd = '0; req = "R10";
    case (op)
      0: begin
        if (hit) req = "R5";
        else begin
          req = mv[idx] ? "R1" : "R3";
          if (mv[idx] && md[idx]) begin req = "R6"; put_back(idx); ew = 1; end
          for (int i = 0; i < LB; i++) mdat[idx][i] = ref_mem[blk*LB + i];
          mv[idx] = 1'b1; md[idx] = 1'b0; mt[idx] = tg; er = 1;
        end
        erd = mdat[idx][off];
      end
      1: begin
        if (hit) begin req = "R4"; mdat[idx][off] = wd; md[idx] = 1'b1; end
        else begin req = "R2"; ref_mem[a] = wd; ew = 1; end
      end
      2: begin
        if (hit && md[idx]) begin req = "R7"; put_back(idx); md[idx] = 1'b0; ew = 1; end
        else req = "R9";
      end
      default: begin
        req = "R8";
        if (hit) begin mv[idx] = 1'b0; md[idx] = 1'b0; end
      end
    endcase

    r0 = n_rd; w0 = n_wr; t = 0;
    while (!req_ready && t < 200) begin @(negedge clk); t++; end
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a[3:0]; req_blk = b[1:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "ready low after accept", int'(req_ready), 0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    check("R10", "response arrives", int'(rsp_valid), 1);
    got = rsp_rdata;
    @(negedge clk);
    check("R10", "response is one cycle", int'(rsp_valid), 0);
    check("R10", "ready back", int'(req_ready), 1);
    if (op == 0) check(req, "read data", int'(got), int'(erd));
    check(req, "memory reads", n_rd - r0, er);
    check(req, "memory writes", n_wr - w0, ew);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] x;
    for (int i = 0; i < NBYTES; i++) begin
      mem_arr[i] = 8'h40 + 8'(i);
      ref_mem[i] = 8'h40 + 8'(i);
    end
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = 0; end
    repeat (3) @(negedge clk);
    check("R11", "ready in reset", int'(req_ready), 1);
    check("R11", "mem_req in reset", int'(mem_req), 0);
    check("R11", "rsp_valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // Directed walk
    run(1, 0, 0, 8'h52);                               // R2 write miss
    check("R2", "mem[0] written", int'(mem_arr[0]), 8'h52);
    run(0, 1, 0, 0);                                   // R3 first fill (R11: all lines empty)
    run(1, 2, 0, 8'h53);                               // R4 write hits
    run(1, 3, 0, 8'h53);
    check("R4", "mem[2] stale", int'(mem_arr[2]), 8'h42);
    run(0, 3, 0, 0);                                   // R5 hit returns cached byte
    run(0, 4, 0, 0);                                   // R1 block 1 -> line 1
    run(0, 1, 0, 0);                                   // R1 block 0 still resident
    check("R1", "block0 and block1 coexist", n_rd, 2);
    run(0, 8, 0, 0);                                   // R6 dirty eviction of block 0
    check("R6", "mem[2] written back", int'(mem_arr[2]), 8'h53);
    run(2, 0, 2, 0);                                   // R9 flush of clean block
    run(1, 9, 0, 8'h5a);                               // R4 make block 2 dirty
    run(2, 0, 2, 0);                                   // R7 flush writes line
    check("R7", "mem[9] after flush", int'(mem_arr[9]), 8'h5a);
    run(0, 9, 0, 0);                                   // R7 still resident
    run(2, 0, 2, 0);                                   // R7 second flush: nothing
    run(1, 5, 0, 8'h54);                               // R4 dirty block 1
    run(3, 0, 1, 0);                                   // R8 discard
    run(0, 5, 0, 0);                                   // R8 refetch old memory byte
    run(2, 0, 0, 0);                                   // R9 non-resident
    run(1, 8, 0, 8'h77);
    run(3, 0, 2, 0);                                   // R8
    run(2, 0, 2, 0);                                   // R9 just invalidated
    check("R9", "mem[8] keeps old value", int'(mem_arr[8]), 8'h48);

    // Pseudo-random sweep over all ops, offsets and blocks
    x = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      run(int'(x[1:0]), int'(x[5:2]), int'(x[7:6]), x[15:8]);
    end

    // Flush every block; memory must then match the model byte for byte
    for (int b = 0; b < NBLK; b++) run(2, 0, b, 0);
    for (int i = 0; i < NBYTES; i++) check("R7", "final memory", int'(mem_arr[i]), int'(ref_mem[i]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule